// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block conditions one asynchronous pad input before its level reaches the pin status read path and the interrupt detector. The pad is first brought into the main clock domain through a two-flop synchronizer. It is then optionally held back by a filter whose time base is a slow free-running clock. Each rising edge of the slow clock is converted into a single-cycle enable in the main domain. A prescaler groups these enables into ticks, and a 4-bit timeout field sets how many ticks a new level must persist.

Two select bits pick the tick length. A 2-bit type field picks the glitch policy: no filtering, immediate falls with delayed rises, immediate rises with delayed falls, or delayed transitions in both directions. Whenever any configuration field changes, the filter drops its pending work and the output takes the current synchronized level.

Top module: `gpio_debounce`

## Requirements
- R1: The pad passes through a two-flop synchronizer, and `level_out` is 0 while `rst_n` is low and directly after reset.
- R2: With `cfg_mode` = 0 (no filtering), `level_out` follows the pad three clock edges after the pad changes.
- R3: With a timeout field `cfg_count` of 0, the filter is bypassed in every mode, exactly as in R2.
- R4: With `cfg_mode` = 3 (remove glitches), `level_out` takes a new level only after the synchronized pad has held that level for `cfg_count` ticks.
- R5: In a filtering mode, a synchronized pad that returns to the current output level before the timeout expires cancels the pending change, and the next change starts its count from zero.
- R6: The tick length in slow-clock rising edges is selected by {`cfg_large`,`cfg_unit`}: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048 (each a parameter).
- R7: With `cfg_mode` = 1 (keep low glitches), a falling pad reaches `level_out` after three edges, and a rising pad must wait out the timeout of R4.
- R8: With `cfg_mode` = 2 (keep high glitches), a rising pad reaches `level_out` after three edges, and a falling pad must wait out the timeout.
- R9: A change in any of `cfg_count`, `cfg_unit`, `cfg_large` or `cfg_mode` clears the prescaler and the timeout count, and loads the synchronized pad level into `level_out` on the next edge.
- R10: Ticks advance only on rising edges of `slow_clk`. While `slow_clk` is stopped, a pending change in a filtering mode never completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow time-base clock, asynchronous to `clk` |
| pad_in | input | 1 | Raw asynchronous pad level |
| cfg_count | input | 4 | Timeout in ticks; 0 disables filtering |
| cfg_unit | input | 1 | Tick-length select, low bit |
| cfg_large | input | 1 | Tick-length select, high bit |
| cfg_mode | input | 2 | Glitch policy: 0 none, 1 keep low glitches, 2 keep high glitches, 3 remove glitches |
| level_out | output | 1 | Filtered pin level |

## Verification
The bench keeps the two short tick lengths at 2 and 8. It sets the two long ones to 16 and 32 so that both large-range selections complete within a few hundred cycles while staying distinct from each other and from the short settings. It runs the slow clock at one eighth of the main clock. Each expected transition is placed in a cycle window derived from ticks times tick length times that period, so a wrong divider or count shows up as a change outside the window. Stopping the slow clock shows that only its edges advance the filter.

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int CNT_W   = 4,
  parameter int DIV_SF  = 2,
  parameter int DIV_SC  = 8,
  parameter int DIV_LF  = 512,
  parameter int DIV_LC  = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             pad_in,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_unit,
  input  logic             cfg_large,
  input  logic [1:0]       cfg_mode,
  output logic             level_out
);
  localparam int MAX_A = (DIV_SF > DIV_SC) ? DIV_SF : DIV_SC;
  localparam int MAX_B = (DIV_LF > DIV_LC) ? DIV_LF : DIV_LC;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PRE_W = (MAX_D > 2) ? $clog2(MAX_D) : 1;
  localparam int CFG_W = CNT_W + 4;

  logic [1:0]       pad_sync, slow_sync;
  logic             slow_d;
  logic             level_q;
  logic [PRE_W-1:0] pre_q, div_m1;
  logic [CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0] cfg_q;

  wire pad_s      = pad_sync[1];
  wire slow_pulse = slow_sync[1] & ~slow_d;
  wire [CFG_W-1:0] cfg_now = {cfg_count, cfg_unit, cfg_large, cfg_mode};
  wire cfg_chg    = cfg_now != cfg_q;
  wire bypass     = (cfg_mode == 2'd0) || (cfg_count == '0);
  wire pending    = pad_s != level_q;
  wire fast       = (cfg_mode == 2'd1 && !pad_s) || (cfg_mode == 2'd2 && pad_s);
  wire tick       = slow_pulse && (pre_q == div_m1);
  wire expire     = tick && (cnt_q == cfg_count - 1'b1);

  always_comb begin
    case ({cfg_large, cfg_unit})
      2'b00:   div_m1 = PRE_W'(DIV_SF - 1);
      2'b01:   div_m1 = PRE_W'(DIV_SC - 1);
      2'b10:   div_m1 = PRE_W'(DIV_LF - 1);
      default: div_m1 = PRE_W'(DIV_LC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_sync  <= '0;
      slow_sync <= '0;
      slow_d    <= 1'b0;
      cfg_q     <= '0;
    end else begin
      pad_sync  <= {pad_sync[0], pad_in};
      slow_sync <= {slow_sync[0], slow_clk};
      slow_d    <= slow_sync[1];
      cfg_q     <= cfg_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else if (cfg_chg || bypass || !pending || fast) begin
      level_q <= pad_s;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else if (slow_pulse) begin
      if (!tick) begin
        pre_q <= pre_q + 1'b1;
      end else begin
        pre_q <= '0;
        if (expire) begin
          level_q <= pad_s;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign level_out = level_q;
endmodule

// File: rtl/gpio_debounce_chk.sv
module gpio_debounce_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pad_s,
  input logic             level_out,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] count,
  input logic             cfg_chg,
  input logic             tick
);
  p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd0) |-> level_out == $past(pad_s));

  p_zero_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == '0) |-> level_out == $past(pad_s));

  p_change_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd3 && $past(count) != '0 && !$past(cfg_chg) &&
     level_out != $past(level_out)) |-> $past(tick));

  p_fast_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd1 && !$past(pad_s)) |-> !level_out);

  p_slow_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd1 && $past(count) != '0 && !$past(cfg_chg) &&
     $rose(level_out)) |-> $past(tick));

  p_fast_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && $past(pad_s)) |-> level_out);

  p_cfg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_chg) |-> level_out == $past(pad_s));
endmodule

bind gpio_debounce gpio_debounce_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_s(pad_s), .level_out(level_out),
  .mode(cfg_mode), .count(cfg_count), .cfg_chg(cfg_chg), .tick(tick)
);

// File: tb/gpio_debounce_bench.sv
module gpio_debounce_bench;
  localparam int SP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_clk = 1'b0;
  logic       pad_in = 1'b0;
  logic [3:0] cfg_count = '0;
  logic       cfg_unit = 1'b0, cfg_large = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic       level_out;

  int cyc = 0, checks = 0, errs = 0, sc_cnt = 0;
  bit slow_run = 1'b1;
  logic prev = 1'b0;
  string cur_req = "R1";

  typedef struct { logic val; int lo; int hi; string req; } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;

  gpio_debounce #(.DIV_SF(2), .DIV_SC(8), .DIV_LF(16), .DIV_LC(32)) u_gpio_debounce (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .pad_in(pad_in),
    .cfg_count(cfg_count), .cfg_unit(cfg_unit), .cfg_large(cfg_large),
    .cfg_mode(cfg_mode), .level_out(level_out)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (slow_run) begin
      sc_cnt = sc_cnt + 1;
      if (sc_cnt == SP / 2) begin
        sc_cnt = 0;
        slow_clk = ~slow_clk;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && level_out !== prev) begin
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL %s: unexpected change at cycle %0d, actual=%b expected=%b",
                 cur_req, cyc, level_out, prev);
      end else begin
        mon_e = exp_q.pop_front();
        if (level_out !== mon_e.val || cyc < mon_e.lo || cyc > mon_e.hi) begin
          errs++;
          $display("FAIL %s: actual=%b at cycle %0d, expected=%b in [%0d,%0d]",
                   mon_e.req, level_out, cyc, mon_e.val, mon_e.lo, mon_e.hi);
        end
      end
      prev = level_out;
    end
  end

  task automatic chk(input logic act, input logic expv, input string req);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic push(input logic v, input int lo, input int hi, input string req);
    exp_t e;
    e.val = v; e.lo = lo; e.hi = hi; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [3:0] c, input logic u, input logic l);
    @(negedge clk);
    cfg_mode = m; cfg_count = c; cfg_unit = u; cfg_large = l;
  endtask

  task automatic drive_imm(input logic v, input string req);
    @(negedge clk);
    cur_req = req;
    pad_in = v;
    push(v, cyc + 1, cyc + 5, req);
  endtask

  task automatic drive_filt(input logic v, input int n, input string req);
    @(negedge clk);
    cur_req = req;
    pad_in = v;
    push(v, cyc + SP * n - SP, cyc + SP * n + 12, req);
  endtask

  task automatic drive_raw(input logic v, input string req);
    @(negedge clk);
    cur_req = req;
    pad_in = v;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 600 && exp_q.size() > 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errs++;
      $display("FAIL %s: actual=%0d pending expected=0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(level_out, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(level_out, 1'b0, "R1");

    // R2: no filtering
    set_cfg(2'd0, 4'd5, 1'b0, 1'b0);
    drive_imm(1'b1, "R2"); repeat (10) @(negedge clk);
    drive_imm(1'b0, "R2"); drain("R2");

    // R3: zero timeout bypasses
    set_cfg(2'd3, 4'd0, 1'b0, 1'b0);
    drive_imm(1'b1, "R3"); repeat (10) @(negedge clk);
    drive_imm(1'b0, "R3"); drain("R3");

    // R4: remove glitches, 3 ticks of 2 edges
    set_cfg(2'd3, 4'd3, 1'b0, 1'b0);
    drive_filt(1'b1, 6, "R4"); drain("R4");
    drive_filt(1'b0, 6, "R4"); drain("R4");

    // R5: short pulse removed, reversal restarts count
    drive_raw(1'b1, "R5"); repeat (20) @(negedge clk);
    drive_raw(1'b0, "R5"); repeat (120) @(negedge clk);
    chk(level_out, 1'b0, "R5");
    drive_raw(1'b1, "R5"); repeat (30) @(negedge clk);
    drive_raw(1'b0, "R5"); repeat (3) @(negedge clk);
    drive_filt(1'b1, 6, "R5"); drain("R5");
    drive_filt(1'b0, 6, "R5"); drain("R5");

    // R6: tick length selections
    set_cfg(2'd3, 4'd2, 1'b1, 1'b0);
    drive_filt(1'b1, 16, "R6"); drain("R6");
    set_cfg(2'd3, 4'd1, 1'b0, 1'b1);
    drive_filt(1'b0, 16, "R6"); drain("R6");
    set_cfg(2'd3, 4'd1, 1'b1, 1'b1);
    drive_filt(1'b1, 32, "R6"); drain("R6");
    drive_filt(1'b0, 32, "R6"); drain("R6");

    // R7: keep low glitches
    set_cfg(2'd1, 4'd2, 1'b0, 1'b0);
    drive_filt(1'b1, 4, "R7"); drain("R7");
    drive_imm(1'b0, "R7"); drain("R7");
    drive_raw(1'b1, "R7"); repeat (10) @(negedge clk);
    drive_raw(1'b0, "R7"); repeat (60) @(negedge clk);
    chk(level_out, 1'b0, "R7");
    drive_filt(1'b1, 4, "R7"); drain("R7");

    // R8: keep high glitches
    set_cfg(2'd2, 4'd2, 1'b0, 1'b0);
    drive_filt(1'b0, 4, "R8"); drain("R8");
    drive_imm(1'b1, "R8"); drain("R8");
    drive_raw(1'b0, "R8"); repeat (10) @(negedge clk);
    drive_raw(1'b1, "R8"); repeat (60) @(negedge clk);
    chk(level_out, 1'b1, "R8");
    drive_filt(1'b0, 4, "R8"); drain("R8");

    // R9: configuration change loads synchronized level
    set_cfg(2'd3, 4'd15, 1'b1, 1'b1);
    drive_raw(1'b1, "R9"); repeat (20) @(negedge clk);
    set_cfg(2'd3, 4'd14, 1'b1, 1'b1);
    push(1'b1, cyc + 1, cyc + 4, "R9"); drain("R9");
    chk(level_out, 1'b1, "R9");
    drive_raw(1'b0, "R9"); repeat (20) @(negedge clk);
    chk(level_out, 1'b1, "R9");
    set_cfg(2'd3, 4'd13, 1'b1, 1'b1);
    push(1'b0, cyc + 1, cyc + 4, "R9"); drain("R9");

    // R10: no slow edges, no progress
    set_cfg(2'd3, 4'd1, 1'b0, 1'b0);
    @(negedge clk); slow_run = 1'b0;
    drive_raw(1'b1, "R10"); repeat (100) @(negedge clk);
    chk(level_out, 1'b0, "R10");
    @(negedge clk); slow_run = 1'b1;
    push(1'b1, cyc + SP * 2 - SP, cyc + SP * 2 + 12, "R10");
    drain("R10");
    chk(level_out, 1'b1, "R10");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule